// File: doc/BRIEF.md
# Three-Mode Power Sequencer

This block steers a processor core between three operating modes: full-speed run, a clock-stopped idle mode in which logic stays powered, and a deep sleep mode in which the core's power domain is switched off. Software or a neighbouring controller asks for a mode change through single-cycle request inputs, and external wake sources raise a wake input. The sequencer gives every change a fixed duration counted in clock cycles. A busy flag covers each change. The block drives a clock-enable for the core clock gate, an enable for the power switch of the core domain, and a two-bit mode code. Other logic can use the mode code as an index into a table of power figures (nominally 400 mW running, 50 mW idle, 0.16 mW asleep).

The changes are not symmetric. Idle is entered and left quickly, with both durations set to 10 µs by default. Sleep is entered from run only, through three consecutive steps of 30 µs each. The power domain is switched off at the end of the third step. Sleep is left through a long restore of about 160 ms, and power returns in its first cycle. Each duration is a microsecond parameter multiplied by a cycles-per-microsecond parameter. A request that arrives while a change is in progress is stored and served once that change has finished.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the mode code is 2'b00 (run), the clock enable and power enable are both 1, and busy is 0.
- R2: An idle request seen in settled run sets busy for exactly IDLE_IN_US*CYC_PER_US cycles. The block then settles with mode code 2'b01 and the clock enable at 0. The clock enable stays 1 throughout this change.
- R3: A wake seen in settled idle sets busy for exactly IDLE_OUT_US*CYC_PER_US cycles with the clock enable at 0. The block then settles in run with the clock enable at 1.
- R4: A sleep request seen in settled run sets busy for three back-to-back steps of STEP_US*CYC_PER_US cycles each. The power enable stays 1 during all three steps. The block then settles with mode code 2'b10 and the power enable at 0. The power enable is 0 only in settled sleep.
- R5: A wake seen in settled sleep raises the power enable in the first busy cycle. Busy then lasts exactly WAKE_US*CYC_PER_US cycles with the clock enable at 0, and the block settles in run.
- R6: A sleep request seen in settled idle first leaves idle as in R3. The block spends one settled run cycle and then performs the sleep entry of R4.
- R7: A request or wake that arrives while busy is high does not shorten or change the current change. It is stored and acted on when the block next settles.
- R8: A wake in settled run, an idle request in settled idle, and an idle or sleep request in settled sleep are discarded. Busy stays 0 and the mode code does not change.
- R9: While busy, the mode code shows the mode being left: 2'b00 while leaving run, 2'b01 while leaving idle, and 2'b10 while leaving sleep.
- R10: When idle and sleep requests are both pending in settled run, sleep entry is chosen and idle is never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req_i | input | 1 | Request to stop the core clock |
| sleep_req_i | input | 1 | Request to remove core power |
| wake_i | input | 1 | Wake event |
| cpu_clk_en_o | output | 1 | Enable for the core clock gate |
| pwr_dom_en_o | output | 1 | Enable for the core power switch |
| mode_o | output | 2 | Mode code: 00 run, 01 idle, 10 sleep |
| busy_o | output | 1 | High during every timed change |

## Verification
The assertions assume that reset is high at the first clock edge and that the three request inputs never carry unknown values after reset. They place no limit on how long a request is held, because a held request is treated as a stored one. The stimulus keeps within these assumptions. It holds reset high for several cycles and then drives each request as a clean one-cycle pulse at the falling clock edge. Some pulses land in a settled mode and others fall in the middle of a timed change.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [3:0] {
        ST_RUN   = 4'd0,
        ST_R2I   = 4'd1,
        ST_IDLE  = 4'd2,
        ST_I2R   = 4'd3,
        ST_SLP1  = 4'd4,
        ST_SLP2  = 4'd5,
        ST_SLP3  = 4'd6,
        ST_SLEEP = 4'd7,
        ST_WAKE  = 4'd8
    } pwr_state_e;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_SLEEP = 2'b10
    } pwr_mode_e;

    typedef struct packed {
        logic idle;
        logic sleep;
        logic wake;
    } pwr_req_t;

    typedef struct packed {
        pwr_mode_e mode;
        logic      clk_en;
        logic      pwr_en;
        logic      busy;
    } pwr_out_t;

    function automatic logic is_timed(pwr_state_e s);
        return !(s == ST_RUN || s == ST_IDLE || s == ST_SLEEP);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_dwell_timer.sv
module pwr_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_req_hold.sv
module pwr_req_hold
    import pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pwr_req_t req_i,
    input  logic     hold_i,
    input  logic     keep_sleep_i,
    output pwr_req_t eff_o
);
    pwr_req_t pend_q;
    pwr_req_t pend_n;

    always_comb begin
        eff_o = pwr_req_t'(pend_q | req_i);
        if (hold_i) begin
            pend_n = eff_o;
        end else begin
            pend_n       = '0;
            pend_n.sleep = keep_sleep_i & eff_o.sleep;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_n;
    end

    // R7: while a timed change runs, no stored request may be lost
    a_r7_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (($past(pend_q) & ~pend_q) == '0));

endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
    import pwr_pkg::*;
(
    input  pwr_state_e state_i,
    output pwr_out_t   out_o
);
    always_comb begin
        out_o.busy   = is_timed(state_i);
        out_o.pwr_en = (state_i != ST_SLEEP);
        unique case (state_i)
            ST_RUN, ST_R2I, ST_SLP1, ST_SLP2, ST_SLP3: begin
                out_o.mode   = MODE_RUN;
                out_o.clk_en = 1'b1;
            end
            ST_IDLE, ST_I2R: begin
                out_o.mode   = MODE_IDLE;
                out_o.clk_en = 1'b0;
            end
            default: begin
                out_o.mode   = MODE_SLEEP;
                out_o.clk_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int CYC_PER_US  = 100,
    parameter int IDLE_IN_US  = 10,
    parameter int IDLE_OUT_US = 10,
    parameter int STEP_US     = 30,
    parameter int WAKE_US     = 160000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_req_i,
    input  logic       sleep_req_i,
    input  logic       wake_i,
    output logic       cpu_clk_en_o,
    output logic       pwr_dom_en_o,
    output logic [1:0] mode_o,
    output logic       busy_o
);
    localparam int T_IN   = CYC_PER_US * IDLE_IN_US;
    localparam int T_OUT  = CYC_PER_US * IDLE_OUT_US;
    localparam int T_STEP = CYC_PER_US * STEP_US;
    localparam int T_WAKE = CYC_PER_US * WAKE_US;
    localparam int T_MAX  = max_of(max_of(T_IN, T_OUT), max_of(T_STEP, T_WAKE));
    localparam int CW     = $clog2(T_MAX + 1);

    localparam logic [CW-1:0] L_IN   = CW'(T_IN - 1);
    localparam logic [CW-1:0] L_OUT  = CW'(T_OUT - 1);
    localparam logic [CW-1:0] L_STEP = CW'(T_STEP - 1);
    localparam logic [CW-1:0] L_WAKE = CW'(T_WAKE - 1);

    pwr_state_e    state_q, state_n;
    pwr_req_t      req, eff;
    pwr_out_t      outs;
    logic          done;
    logic          load;
    logic [CW-1:0] load_val;

    assign req = '{idle: idle_req_i, sleep: sleep_req_i, wake: wake_i};

    pwr_req_hold u_req (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .hold_i       (is_timed(state_q)),
        .keep_sleep_i (state_q == ST_IDLE),
        .eff_o        (eff)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN:   if (eff.sleep) state_n = ST_SLP1;
                      else if (eff.idle) state_n = ST_R2I;
            ST_R2I:   if (done) state_n = ST_IDLE;
            ST_IDLE:  if (eff.wake || eff.sleep) state_n = ST_I2R;
            ST_I2R:   if (done) state_n = ST_RUN;
            ST_SLP1:  if (done) state_n = ST_SLP2;
            ST_SLP2:  if (done) state_n = ST_SLP3;
            ST_SLP3:  if (done) state_n = ST_SLEEP;
            ST_SLEEP: if (eff.wake) state_n = ST_WAKE;
            ST_WAKE:  if (done) state_n = ST_RUN;
            default:  state_n = ST_RUN;
        endcase
    end

    always_comb begin
        load = (state_n != state_q) && is_timed(state_n);
        unique case (state_n)
            ST_R2I:                    load_val = L_IN;
            ST_I2R:                    load_val = L_OUT;
            ST_SLP1, ST_SLP2, ST_SLP3: load_val = L_STEP;
            ST_WAKE:                   load_val = L_WAKE;
            default:                   load_val = '0;
        endcase
    end

    pwr_dwell_timer #(.W(CW)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i (load_val),
        .done_o     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_n;
    end

    pwr_out_decode u_dec (
        .state_i (state_q),
        .out_o   (outs)
    );

    assign cpu_clk_en_o = outs.clk_en;
    assign pwr_dom_en_o = outs.pwr_en;
    assign mode_o       = outs.mode;
    assign busy_o       = outs.busy;

    // R2: a timed change holds its state until the timer has run out
    a_r2_dwell_hold: assert property (@(posedge clk) disable iff (rst)
        (is_timed(state_q) && !done) |=> (state_q == $past(state_q)));

    // R3: the core clock restarts only on arrival in run from a timed exit
    a_r3_clk_resume: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en_o) |-> (state_q == ST_RUN &&
                                 ($past(state_q) == ST_I2R || $past(state_q) == ST_WAKE)));

    // R4: power is removed only when the third entry step ends
    a_r4_pwr_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_dom_en_o) |-> ($past(state_q) == ST_SLP3 && mode_o == 2'b10 && !busy_o));

    // R5: power returns in the first cycle of the wake sequence
    a_r5_pwr_back: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_dom_en_o) |-> (busy_o && mode_o == 2'b10 && !cpu_clk_en_o));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int CPU    = 2;
    localparam int T_IN   = CPU * 3;
    localparam int T_OUT  = CPU * 4;
    localparam int T_STEP = CPU * 5;
    localparam int T_WAKE = CPU * 40;

    localparam int P_RUN = 0, P_R2I = 1, P_IDLE = 2, P_I2R = 3;
    localparam int P_S1 = 4, P_S2 = 5, P_S3 = 6, P_SLEEP = 7, P_WAKE = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic idle_req = 1'b0, sleep_req = 1'b0, wake = 1'b0;
    logic clk_en, pwr_en, busy;
    logic [1:0] mode;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(
        .CYC_PER_US(CPU), .IDLE_IN_US(3), .IDLE_OUT_US(4), .STEP_US(5), .WAKE_US(40)
    ) u0 (
        .clk(clk), .rst(rst), .idle_req_i(idle_req), .sleep_req_i(sleep_req),
        .wake_i(wake), .cpu_clk_en_o(clk_en), .pwr_dom_en_o(pwr_en),
        .mode_o(mode), .busy_o(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference: phase, remaining cycles, stored requests
    int ph = P_RUN;
    int rem = 0;
    bit p_i = 0, p_s = 0, p_w = 0;
    bit ei, es, ew;
    int x_mode, x_clk, x_pwr, x_busy;

    always @(posedge clk) begin
        if (rst) begin
            ph = P_RUN; rem = 0; p_i = 0; p_s = 0; p_w = 0;
        end else begin
            ei = p_i | idle_req; es = p_s | sleep_req; ew = p_w | wake;
            if (ph == P_RUN) begin
                p_i = 0; p_s = 0; p_w = 0;
                if (es) begin ph = P_S1; rem = T_STEP; end
                else if (ei) begin ph = P_R2I; rem = T_IN; end
            end else if (ph == P_IDLE) begin
                p_i = 0; p_w = 0; p_s = es;
                if (ew || es) begin ph = P_I2R; rem = T_OUT; end
            end else if (ph == P_SLEEP) begin
                p_i = 0; p_s = 0; p_w = 0;
                if (ew) begin ph = P_WAKE; rem = T_WAKE; end
            end else begin
                p_i = ei; p_s = es; p_w = ew;
                rem--;
                if (rem == 0) begin
                    case (ph)
                        P_R2I: ph = P_IDLE;
                        P_I2R: ph = P_RUN;
                        P_S1:  begin ph = P_S2; rem = T_STEP; end
                        P_S2:  begin ph = P_S3; rem = T_STEP; end
                        P_S3:  ph = P_SLEEP;
                        default: ph = P_RUN;
                    endcase
                end
            end
        end
        x_mode = (ph == P_IDLE || ph == P_I2R) ? 1 : (ph == P_SLEEP || ph == P_WAKE) ? 2 : 0;
        x_clk  = (ph == P_RUN || ph == P_R2I || ph == P_S1 || ph == P_S2 || ph == P_S3) ? 1 : 0;
        x_pwr  = (ph == P_SLEEP) ? 0 : 1;
        x_busy = (ph == P_RUN || ph == P_IDLE || ph == P_SLEEP) ? 0 : 1;
        #1;
        if (!finished) begin
            chk("R9 mode code vs model", int'(mode), x_mode);
            chk("R2 clock enable vs model", int'(clk_en), x_clk);
            chk("R4 power enable vs model", int'(pwr_en), x_pwr);
            chk("R7 busy vs model", int'(busy), x_busy);
        end
    end

    task automatic pulse(input bit i, input bit s, input bit w);
        @(negedge clk);
        idle_req = i; sleep_req = s; wake = w;
        @(negedge clk);
        idle_req = 0; sleep_req = 0; wake = 0;
    endtask

    task automatic wait_mode(input string tag, input int target, input int exp_busy);
        int n = 0;
        bit ok = 0;
        for (int k = 0; k < 2000; k++) begin
            if (busy) n++;
            if (!busy && int'(mode) == target) begin ok = 1; break; end
            @(negedge clk);
        end
        chk({tag, " settled"}, int'(ok), 1);
        chk({tag, " busy cycles"}, n, exp_busy);
    endtask

    task automatic quiet(input string tag, input int exp_mode);
        int nb = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy) nb++;
        end
        chk({tag, " no busy"}, nb, 0);
        chk({tag, " mode kept"}, int'(mode), exp_mode);
    endtask

    initial begin : watchdog
        #400000;
        if (!finished) begin
            finished = 1;
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset clk_en", int'(clk_en), 1);
        chk("R1 reset pwr_en", int'(pwr_en), 1);
        chk("R1 reset busy", int'(busy), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 after reset busy", int'(busy), 0);
        chk("R1 after reset mode", int'(mode), 0);

        pulse(1, 0, 0);
        chk("R2 clk_en during entry", int'(clk_en), 1);
        wait_mode("R2 run to idle", 1, T_IN);
        chk("R2 clk_en in idle", int'(clk_en), 0);

        pulse(1, 0, 0);
        quiet("R8 idle request in idle", 1);

        pulse(0, 0, 1);
        chk("R3 clk_en during exit", int'(clk_en), 0);
        chk("R9 mode while leaving idle", int'(mode), 1);
        wait_mode("R3 idle to run", 0, T_OUT);
        chk("R3 clk_en in run", int'(clk_en), 1);

        pulse(0, 0, 1);
        quiet("R8 wake in run", 0);

        pulse(0, 1, 0);
        chk("R4 pwr_en in step", int'(pwr_en), 1);
        chk("R9 mode while leaving run", int'(mode), 0);
        wait_mode("R4 run to sleep", 2, 3 * T_STEP);
        chk("R4 pwr_en in sleep", int'(pwr_en), 0);

        pulse(1, 1, 0);
        quiet("R8 requests in sleep", 2);
        chk("R8 pwr_en stays off", int'(pwr_en), 0);

        pulse(0, 0, 1);
        chk("R5 pwr_en first wake cycle", int'(pwr_en), 1);
        chk("R5 clk_en during wake", int'(clk_en), 0);
        chk("R9 mode while leaving sleep", int'(mode), 2);
        wait_mode("R5 sleep to run", 0, T_WAKE);

        pulse(1, 0, 0);
        pulse(0, 0, 1);
        wait_mode("R7 wake stored during idle entry", 0, T_IN - 2 + T_OUT);

        pulse(1, 0, 0);
        wait_mode("R6 setup idle", 1, T_IN);
        pulse(0, 1, 0);
        wait_mode("R6 idle to sleep via run", 2, T_OUT + 3 * T_STEP);
        pulse(0, 0, 1);
        wait_mode("R6 back to run", 0, T_WAKE);

        pulse(1, 1, 0);
        wait_mode("R10 sleep chosen over idle", 2, 3 * T_STEP);
        pulse(0, 0, 1);
        wait_mode("R10 back to run", 0, T_WAKE);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule